// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block times the two halves of every SCL period for an I2C master. A free-running prescaler turns the system clock into a slower count tick, and a small phase controller spends a programmed number of ticks with SCL pulled low, then releases it.

After release, the controller does not start timing the high half straight away. It waits until the sampled SCL line is actually seen high at a tick, so the bus rise time and any clock stretching by a slave add to the period instead of eating into it. Only then does it time the programmed high count. The low and high counts are 9 bits each. Each one is supplied as an 8-bit value plus a separate top bit.

Two single-cycle strobes mark the phase edges. One fires when the block drives SCL low and the other when the line is sensed high. The byte engine that sequences SDA uses these strobes. All pins are plain level or pulse control signals. There is no data stream, so there is no valid/ready handshake and no back-pressure to honour.

Top module: `scl_period_gen`

## Requirements
- R1: The count tick occurs once every `div` system clocks, where `div` is the prescale input. A value of 0 behaves as 1. Phase lengths below are given in ticks, so in system clocks they scale by this factor.
- R2: The low count is `{lo_msb_i, lo_cnt_i}` and the high count is `{hi_msb_i, hi_cnt_i}`, with the separate bit as bit 8. A count of 0 behaves as 1.
- R3: `fall_stb_o` pulses in the same cycle that `scl_pull_o` rises. `scl_pull_o` then stays high for exactly low-count × div clocks.
- R4: After releasing SCL, the block waits with no timeout until `scl_in_i` is high at a tick. While the line stays low, no rise strobe is issued and the high phase does not advance.
- R5: From the cycle of `rise_stb_o` to the cycle of the next `fall_stb_o` is exactly high-count × div clocks.
- R6: Each strobe lasts one cycle, and the two never fire together. `rise_stb_o` fires only when `scl_in_i` was high at the preceding edge and SCL is released.
- R7: While `en_i` is low, SCL is released by the next tick and no fall strobe is issued. On re-enable, the block starts with a full low phase.
- R8: After reset, `scl_pull_o`, `rise_stb_o` and `fall_stb_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run the SCL clock |
| clk_div_i | input | 8 | System clocks per count tick (0 acts as 1) |
| lo_cnt_i | input | 8 | Low count, bits 7:0 |
| lo_msb_i | input | 1 | Low count, bit 8 |
| hi_cnt_i | input | 8 | High count, bits 7:0 |
| hi_msb_i | input | 1 | High count, bit 8 |
| scl_in_i | input | 1 | Synchronised SCL line level |
| scl_pull_o | output | 1 | Drive SCL low when 1 |
| rise_stb_o | output | 1 | One-cycle pulse: SCL sensed high |
| fall_stb_o | output | 1 | One-cycle pulse: SCL pulled low |

## Verification
The hardest situation to reach is a slave holding SCL low well past the release, because the high phase must neither start early nor count the wait. The bench models the bus line as a delayed copy of the released pull, with a per-configuration rise delay that ranges from one clock to several dozen. For every prescale and count pair in the sweep, it then checks two things: that the rise strobe lands inside the window the delay and tick spacing allow, and that the high phase still lasts exactly its programmed length. The sweep includes counts of zero and counts that use the ninth bit.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } scl_phase_e;
endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] acc_q;
  logic [DIV_W-1:0] lim;

  // Divisor 0 behaves as 1: limit of 0 gives a tick every cycle.
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (acc_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (tick_o) acc_q <= '0;
    else             acc_q <= acc_q + 1'b1;
  end
endmodule

// File: rtl/scl_count_join.sv
module scl_count_join #(
  parameter int PART_W = 8
) (
  input  logic [PART_W-1:0] part_i,
  input  logic              msb_i,
  output logic [PART_W:0]   eff_o
);
  logic [PART_W:0] raw;

  assign raw   = {msb_i, part_i};
  assign eff_o = (raw == '0) ? {{PART_W{1'b0}}, 1'b1} : raw;
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             scl_in_i,
  input  logic [CNT_W-1:0] lo_lim_i,
  input  logic [CNT_W-1:0] hi_lim_i,
  output logic             pull_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  scl_phase_e      ph_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      pull_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (tick_i) begin
        if (!en_i) begin
          ph_q   <= PH_IDLE;
          cnt_q  <= '0;
          pull_o <= 1'b0;
        end else begin
          case (ph_q)
            PH_IDLE: begin
              ph_q   <= PH_LOW;
              cnt_q  <= ONE;
              pull_o <= 1'b1;
              fall_o <= 1'b1;
            end
            PH_LOW: begin
              if (cnt_q >= lo_lim_i) begin
                ph_q   <= PH_WAIT;
                cnt_q  <= '0;
                pull_o <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            PH_WAIT: begin
              if (scl_in_i) begin
                ph_q   <= PH_HIGH;
                cnt_q  <= ONE;
                rise_o <= 1'b1;
              end
            end
            PH_HIGH: begin
              if (cnt_q >= hi_lim_i) begin
                ph_q   <= PH_LOW;
                cnt_q  <= ONE;
                pull_o <= 1'b1;
                fall_o <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: begin
              ph_q   <= PH_IDLE;
              cnt_q  <= '0;
              pull_o <= 1'b0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int DIV_W  = 8,
  parameter int PART_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [PART_W-1:0] lo_cnt_i,
  input  logic              lo_msb_i,
  input  logic [PART_W-1:0] hi_cnt_i,
  input  logic              hi_msb_i,
  input  logic              scl_in_i,
  output logic              scl_pull_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o
);
  localparam int CNT_W  = PART_W + 1;
  localparam int N_PHSE = 2;

  logic                          tick;
  logic [N_PHSE-1:0][PART_W-1:0] parts;
  logic [N_PHSE-1:0]             msbs;
  logic [N_PHSE-1:0][CNT_W-1:0]  lims;

  assign parts = {hi_cnt_i, lo_cnt_i};
  assign msbs  = {hi_msb_i, lo_msb_i};

  scl_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  for (genvar g = 0; g < N_PHSE; g++) begin : g_join
    scl_count_join #(.PART_W(PART_W)) u_join (
      .part_i (parts[g]),
      .msb_i  (msbs[g]),
      .eff_o  (lims[g])
    );
  end

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .en_i     (en_i),
    .scl_in_i (scl_in_i),
    .lo_lim_i (lims[0]),
    .hi_lim_i (lims[1]),
    .pull_o   (scl_pull_o),
    .rise_o   (rise_stb_o),
    .fall_o   (fall_stb_o)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic scl_in_i,
  input logic scl_pull_o,
  input logic rise_stb_o,
  input logic fall_stb_o
);
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb_o && fall_stb_o));
  a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |=> !rise_stb_o);
  a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |=> !fall_stb_o);
  a_r6_rise_sensed: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |-> ($past(scl_in_i) && !scl_pull_o));
  a_r4_no_rise_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scl_in_i) |-> !rise_stb_o);
  a_r3_fall_with_pull: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |-> (scl_pull_o && !$past(scl_pull_o)));
  a_r3_pull_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> fall_stb_o);
  a_r7_fall_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |-> $past(en_i));
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .scl_in_i   (scl_in_i),
  .scl_pull_o (scl_pull_o),
  .rise_stb_o (rise_stb_o),
  .fall_stb_o (fall_stb_o)
);

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] clk_div_i = 8'd1;
  logic [7:0] lo_cnt_i = '0;
  logic       lo_msb_i = 1'b0;
  logic [7:0] hi_cnt_i = '0;
  logic       hi_msb_i = 1'b0;
  logic       scl_in_i = 1'b1;
  logic       scl_pull_o, rise_stb_o, fall_stb_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int cur_div = 1, exp_lo = 1, exp_hi = 1, cur_dly = 1;
  bit mon_on = 1'b0;
  bit lo_act = 1'b0, hi_act = 1'b0, wait_act = 1'b0;
  int lo_len = 0, hi_len = 0, rel_cnt = 0, n_rise = 0;

  always #5 clk = ~clk;

  scl_period_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .clk_div_i  (clk_div_i),
    .lo_cnt_i   (lo_cnt_i),
    .lo_msb_i   (lo_msb_i),
    .hi_cnt_i   (hi_cnt_i),
    .hi_msb_i   (hi_msb_i),
    .scl_in_i   (scl_in_i),
    .scl_pull_o (scl_pull_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (div %0d lo %0d hi %0d dly %0d)",
               req, act, exp, cur_div, exp_lo, exp_hi, cur_dly);
    end
  endtask

  // Monitor and bus model: checks first, then the line level is updated.
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (fall_stb_o) begin
        if (hi_act) chk(hi_len == exp_hi * cur_div, "R5 high length", hi_len, exp_hi * cur_div);
        hi_act = 1'b0;
        lo_act = 1'b1;
        lo_len = 1;
        chk(scl_pull_o, "R3 pull with fall strobe", scl_pull_o, 1);
      end else if (lo_act && scl_pull_o) begin
        lo_len++;
      end else if (lo_act && !scl_pull_o) begin
        chk(lo_len == exp_lo * cur_div, "R3 low length", lo_len, exp_lo * cur_div);
        lo_act = 1'b0;
        wait_act = 1'b1;
      end
      if (rise_stb_o) begin
        chk(scl_in_i, "R6 rise only when sensed high", scl_in_i, 1);
        if (wait_act)
          chk(rel_cnt >= cur_dly && rel_cnt <= cur_dly + cur_div + 1,
              "R4 wait for line high", rel_cnt, cur_dly);
        wait_act = 1'b0;
        hi_act = 1'b1;
        hi_len = 1;
        n_rise++;
      end else if (hi_act) begin
        hi_len++;
      end
    end else begin
      lo_act = 1'b0;
      hi_act = 1'b0;
      wait_act = 1'b0;
    end
    if (scl_pull_o) rel_cnt = 0;
    else if (rel_cnt < 100000) rel_cnt++;
    scl_in_i = !scl_pull_o && (rel_cnt >= cur_dly);
  end

  task automatic run_cfg(input int dv, input int lo, input int hi, input int dly);
    int guard;
    @(negedge clk);
    mon_on = 1'b0;
    en_i = 1'b0;
    repeat (dv + 3) @(negedge clk);
    clk_div_i = dv[7:0];
    lo_cnt_i = lo[7:0];
    lo_msb_i = lo[8];
    hi_cnt_i = hi[7:0];
    hi_msb_i = hi[8];
    cur_div = (dv == 0) ? 1 : dv;   // R1: 0 acts as 1
    exp_lo = (lo == 0) ? 1 : lo;    // R2: 0 acts as 1
    exp_hi = (hi == 0) ? 1 : hi;
    cur_dly = dly;
    n_rise = 0;
    repeat (cur_div + 2) @(negedge clk);
    mon_on = 1'b1;
    en_i = 1'b1;
    guard = 0;
    while (n_rise < 3 && guard < 4 * (exp_lo + exp_hi + dly + 4) * cur_div) begin
      @(negedge clk);
      guard++;
    end
    // Finish one more high phase so its length is measured.
    while (hi_act && guard < 6 * (exp_lo + exp_hi + dly + 4) * cur_div) begin
      @(negedge clk);
      guard++;
    end
    chk(n_rise >= 3, "R5 periods completed", n_rise, 3);
    // R7: disable mid-low-phase, release within one tick, no fall strobe after.
    while (!scl_pull_o && guard < 8 * (exp_lo + exp_hi + dly + 4) * cur_div) begin
      @(negedge clk);
      guard++;
    end
    mon_on = 1'b0;
    en_i = 1'b0;
    repeat (cur_div + 1) @(negedge clk);
    chk(!scl_pull_o, "R7 released after disable", scl_pull_o, 0);
    begin
      int nf = 0;
      for (int k = 0; k < 3 * cur_div + 4; k++) begin
        @(negedge clk);
        if (fall_stb_o || scl_pull_o) nf++;
      end
      chk(nf == 0, "R7 idle while disabled", nf, 0);
    end
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int dvs[3] = '{1, 2, 3};
    int los[6] = '{0, 1, 4, 257, 3, 2};
    int his[6] = '{0, 2, 3, 2, 300, 1};
    int dls[6] = '{1, 1, 6, 2, 25, 40};
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!scl_pull_o && !rise_stb_o && !fall_stb_o, "R8 reset outputs",
        {scl_pull_o, rise_stb_o, fall_stb_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull_o && !rise_stb_o && !fall_stb_o, "R8 idle after reset",
        {scl_pull_o, rise_stb_o, fall_stb_o}, 0);
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 6; p++)
        run_cfg(dvs[d], los[p], his[p], dls[p]);
    // R1: divisor 0 acts as 1
    run_cfg(0, 5, 4, 3);
    // R7: re-enable after disable starts a full low phase again
    run_cfg(2, 6, 2, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule